// File: doc/BRIEF.md
# Hardware Breakpoint Match Unit

The block watches a processor's memory accesses and raises a debug-exception pulse when one of them hits an armed breakpoint. It holds four breakpoint linear addresses, a control word and a status word. Every cycle it compares the presented access against all four breakpoints at once. An access carries a linear address, a kind (instruction fetch, data read or data write) and a valid strobe. A breakpoint matches only when the access kind fits its type code and the address falls inside the byte, halfword or word that its length code covers.

Each breakpoint has a local and a global enable. A task switch drops the local enables and keeps the global ones. A match always leaves a sticky flag in the status word, even when the breakpoint is disabled. The exception pulse fires only when at least one matching breakpoint is enabled. The status word also collects a single-step flag and a task-trap flag. Software at privilege level 0 reads and writes all registers through a simple port. Any access from another level is refused and flagged.

Top module: `brk_match_unit`

## Requirements
- R1: After reset the four address registers, the control word and the status word read as zero, and `dbg_exc_o` and `prot_fault_o` are low.
- R2: Register select codes: 0..3 pick breakpoint address 0..3, 6 the status word, 7 the control word. Codes 4 and 5 are reserved: they read as zero and ignore writes. Reads are combinational while `reg_en_i` is high and `reg_we_i` is low. Writes take effect at the clock edge.
- R3: An access with `reg_en_i` high and `cpl_i` not 0 drives `prot_fault_o` high in the same cycle and returns zero read data. It changes no register.
- R4: Access kinds are 00 fetch, 01 read and 10 write; 11 never matches. A breakpoint's type sits at control bits [17+4n:16+4n]. Type 00 matches fetches only, 01 writes only, and 11 reads or writes but not fetches.
- R5: A breakpoint's length sits at control bits [19+4n:18+4n]. Length 00 compares every address bit. Length 01 ignores bit 0 and 11 ignores bits 1:0, on both the breakpoint and the access address.
- R6: Type 10, length 10, and type 00 with any length other than 00 never match.
- R7: A match sets status bit n whether or not breakpoint n is enabled. With both of its enables clear, no exception follows.
- R8: The local enable of breakpoint n is control bit 2n and the global enable is bit 2n+1. A matching access with either enable set makes `dbg_exc_o` high for exactly the one cycle after the access edge.
- R9: Status bits are sticky. Only a privileged write to the status word changes them. A match in the same cycle as such a write still leaves its bit set.
- R10: `task_switch_i` clears the local enables and the local exact bit (control bit 8). The global enables and the global exact bit (bit 9) are kept. The clear wins over a control write in the same cycle.
- R11: `single_step_i` sets status bit 14. `task_switch_i` together with `new_task_trap_i` sets status bit 15. A task switch without the trap flag leaves bit 15 alone.
- R12: With `acc_valid_i` low no breakpoint matches: no status bit is set and no exception follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Access strobe |
| acc_addr_i | input | 32 | Access linear address |
| acc_kind_i | input | 2 | Access kind: 00 fetch, 01 read, 10 write |
| reg_en_i | input | 1 | Register port access |
| reg_we_i | input | 1 | Register port write (else read) |
| reg_sel_i | input | 3 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| cpl_i | input | 2 | Current privilege level of the requester |
| reg_rdata_o | output | 32 | Register read data |
| prot_fault_o | output | 1 | Refused register access |
| task_switch_i | input | 1 | Task switch event, one cycle |
| new_task_trap_i | input | 1 | Trap flag of the incoming task |
| single_step_i | input | 1 | Single-step event |
| dbg_exc_o | output | 1 | Debug exception pulse |

## Verification
The assertions assume that `task_switch_i` and `single_step_i` are one-cycle events. They also assume that a refused register access is the only thing that must leave the address registers alone, which holds because only privileged writes load them. Control stability after a refused access is claimed only when no task switch happens in the same cycle. The stimulus changes every input at the falling edge, drives task switches and single steps as single-cycle pulses, and clears the status word before each table entry so that each flag it reads comes from that entry alone.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int unsigned NUM_BP   = 4;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned SEL_W    = 3;

  localparam int unsigned CTRL_LEXACT  = 8;
  localparam int unsigned CTRL_GEXACT  = 9;
  localparam int unsigned CTRL_CFG_LSB = 16;
  localparam int unsigned CFG_STRIDE   = 4;
  localparam int unsigned STAT_SS_BIT  = 14;
  localparam int unsigned STAT_TT_BIT  = 15;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_READ  = 2'b01,
    ACC_WRITE = 2'b10,
    ACC_NONE  = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    BT_EXEC  = 2'b00,
    BT_WR    = 2'b01,
    BT_UNDEF = 2'b10,
    BT_RW    = 2'b11
  } bp_type_e;

  typedef enum logic [1:0] {
    BL_1     = 2'b00,
    BL_2     = 2'b01,
    BL_UNDEF = 2'b10,
    BL_4     = 2'b11
  } bp_len_e;

  typedef enum logic [2:0] {
    SEL_BP0  = 3'd0,
    SEL_BP1  = 3'd1,
    SEL_BP2  = 3'd2,
    SEL_BP3  = 3'd3,
    SEL_RSV4 = 3'd4,
    SEL_RSV5 = 3'd5,
    SEL_STAT = 3'd6,
    SEL_CTRL = 3'd7
  } reg_sel_e;

  // bits cleared by a task switch: local enables plus local exact
  function automatic logic [DATA_W-1:0] local_mask(int unsigned nbp);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < nbp; i++) m[2*i] = 1'b1;
    m[CTRL_LEXACT] = 1'b1;
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] global_mask(int unsigned nbp);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < nbp; i++) m[2*i+1] = 1'b1;
    m[CTRL_GEXACT] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/brk_cmp.sv
module brk_cmp
  import brk_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic [AW-1:0] bp_addr_i,
  input  logic [1:0]    type_i,
  input  logic [1:0]    len_i,
  input  logic          acc_valid_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic [1:0]    acc_kind_i,
  output logic          hit_o
);
  logic [AW-1:0] mask;
  logic          len_ok;
  logic          type_ok;

  always_comb begin
    mask   = '1;
    len_ok = 1'b1;
    unique case (len_i)
      BL_1:    mask = '1;
      BL_2:    mask[0] = 1'b0;
      BL_4:    mask[1:0] = 2'b00;
      default: len_ok = 1'b0;
    endcase
  end

  always_comb begin
    unique case (type_i)
      BT_EXEC: type_ok = (acc_kind_i == ACC_FETCH) && (len_i == BL_1);
      BT_WR:   type_ok = (acc_kind_i == ACC_WRITE);
      BT_RW:   type_ok = (acc_kind_i == ACC_READ) || (acc_kind_i == ACC_WRITE);
      default: type_ok = 1'b0;
    endcase
  end

  assign hit_o = acc_valid_i && len_ok && type_ok &&
                 (((bp_addr_i ^ acc_addr_i) & mask) == '0);
endmodule

// File: rtl/brk_regs.sv
module brk_regs
  import brk_pkg::*;
#(
  parameter int unsigned NBP = NUM_BP,
  parameter int unsigned AW  = ADDR_W,
  parameter int unsigned DW  = DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_en_i,
  input  logic              reg_we_i,
  input  logic [SEL_W-1:0]  reg_sel_i,
  input  logic [DW-1:0]     reg_wdata_i,
  input  logic [1:0]        cpl_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              prot_fault_o,
  input  logic [NBP-1:0]    hit_i,
  input  logic              task_switch_i,
  input  logic              new_task_trap_i,
  input  logic              single_step_i,
  output logic [NBP*AW-1:0] bp_addr_o,
  output logic [DW-1:0]     ctrl_o,
  output logic [DW-1:0]     stat_o
);
  localparam logic [DW-1:0] LMASK = local_mask(NBP);

  logic          acc_ok;
  logic          wr_ok;
  logic [DW-1:0] ctrl_q, ctrl_d;
  logic [DW-1:0] stat_q, stat_d;

  assign acc_ok       = reg_en_i && (cpl_i == 2'd0);
  assign wr_ok        = acc_ok && reg_we_i;
  assign prot_fault_o = reg_en_i && (cpl_i != 2'd0);

  for (genvar n = 0; n < NBP; n++) begin : g_addr
    logic [AW-1:0] addr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     addr_q <= '0;
      else if (wr_ok && reg_sel_i == SEL_W'(n))        addr_q <= reg_wdata_i[AW-1:0];
    end
    assign bp_addr_o[n*AW +: AW] = addr_q;
  end

  always_comb begin
    ctrl_d = (wr_ok && reg_sel_i == SEL_CTRL) ? reg_wdata_i : ctrl_q;
    if (task_switch_i) ctrl_d = ctrl_d & ~LMASK;
  end

  always_comb begin
    stat_d = (wr_ok && reg_sel_i == SEL_STAT) ? reg_wdata_i : stat_q;
    stat_d[NBP-1:0] = stat_d[NBP-1:0] | hit_i;
    if (single_step_i)                  stat_d[STAT_SS_BIT] = 1'b1;
    if (task_switch_i && new_task_trap_i) stat_d[STAT_TT_BIT] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      stat_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      stat_q <= stat_d;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (acc_ok && !reg_we_i) begin
      unique case (reg_sel_i)
        SEL_STAT: reg_rdata_o = stat_q;
        SEL_CTRL: reg_rdata_o = ctrl_q;
        SEL_RSV4, SEL_RSV5: reg_rdata_o = '0;
        default: begin
          for (int unsigned i = 0; i < NBP; i++)
            if (reg_sel_i == SEL_W'(i)) reg_rdata_o = DW'(bp_addr_o[i*AW +: AW]);
        end
      endcase
    end
  end

  assign ctrl_o = ctrl_q;
  assign stat_o = stat_q;
endmodule

// File: rtl/brk_match_unit.sv
module brk_match_unit
  import brk_pkg::*;
#(
  parameter int unsigned NBP = NUM_BP,
  parameter int unsigned AW  = ADDR_W,
  parameter int unsigned DW  = DATA_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_valid_i,
  input  logic [AW-1:0]    acc_addr_i,
  input  logic [1:0]       acc_kind_i,
  input  logic             reg_en_i,
  input  logic             reg_we_i,
  input  logic [SEL_W-1:0] reg_sel_i,
  input  logic [DW-1:0]    reg_wdata_i,
  input  logic [1:0]       cpl_i,
  output logic [DW-1:0]    reg_rdata_o,
  output logic             prot_fault_o,
  input  logic             task_switch_i,
  input  logic             new_task_trap_i,
  input  logic             single_step_i,
  output logic             dbg_exc_o
);
  logic [NBP*AW-1:0] bp_addr_w;
  logic [DW-1:0]     ctrl_w;
  logic [DW-1:0]     stat_w;
  logic [NBP-1:0]    hit_w;
  logic [NBP-1:0]    en_w;
  logic              exc_q;

  brk_regs #(.NBP(NBP), .AW(AW), .DW(DW)) u_regs (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .reg_en_i        (reg_en_i),
    .reg_we_i        (reg_we_i),
    .reg_sel_i       (reg_sel_i),
    .reg_wdata_i     (reg_wdata_i),
    .cpl_i           (cpl_i),
    .reg_rdata_o     (reg_rdata_o),
    .prot_fault_o    (prot_fault_o),
    .hit_i           (hit_w),
    .task_switch_i   (task_switch_i),
    .new_task_trap_i (new_task_trap_i),
    .single_step_i   (single_step_i),
    .bp_addr_o       (bp_addr_w),
    .ctrl_o          (ctrl_w),
    .stat_o          (stat_w)
  );

  for (genvar n = 0; n < NBP; n++) begin : g_cmp
    localparam int unsigned CFG = CTRL_CFG_LSB + CFG_STRIDE * n;
    brk_cmp #(.AW(AW)) u_cmp (
      .bp_addr_i   (bp_addr_w[n*AW +: AW]),
      .type_i      (ctrl_w[CFG +: 2]),
      .len_i       (ctrl_w[CFG+2 +: 2]),
      .acc_valid_i (acc_valid_i),
      .acc_addr_i  (acc_addr_i),
      .acc_kind_i  (acc_kind_i),
      .hit_o       (hit_w[n])
    );
    assign en_w[n] = ctrl_w[2*n] | ctrl_w[2*n+1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) exc_q <= 1'b0;
    else         exc_q <= |(hit_w & en_w);
  end

  assign dbg_exc_o = exc_q;
endmodule

// File: rtl/brk_match_unit_chk.sv
module brk_match_unit_chk
  import brk_pkg::*;
#(
  parameter int unsigned NBP = NUM_BP,
  parameter int unsigned AW  = ADDR_W,
  parameter int unsigned DW  = DATA_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              acc_valid_i,
  input logic              reg_en_i,
  input logic              reg_we_i,
  input logic [SEL_W-1:0]  reg_sel_i,
  input logic [1:0]        cpl_i,
  input logic [DW-1:0]     reg_rdata_o,
  input logic              prot_fault_o,
  input logic              task_switch_i,
  input logic              single_step_i,
  input logic              dbg_exc_o,
  input logic [NBP*AW-1:0] bp_addr,
  input logic [DW-1:0]     ctrl,
  input logic [DW-1:0]     stat
);
  localparam logic [DW-1:0] LM = local_mask(NBP);
  localparam logic [DW-1:0] GM = global_mask(NBP);

  logic stat_wr, ctrl_wr;
  assign stat_wr = reg_en_i && reg_we_i && cpl_i == 2'd0 && reg_sel_i == SEL_STAT;
  assign ctrl_wr = reg_en_i && reg_we_i && cpl_i == 2'd0 && reg_sel_i == SEL_CTRL;

  assert_fault_rdata_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_fault_o |-> reg_rdata_o == '0);
  assert_fault_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_fault_o |=> $stable(bp_addr));
  assert_fault_ctrl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_fault_o && !task_switch_i |=> $stable(ctrl));
  assert_exc_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_exc_o |-> stat[NBP-1:0] != '0);
  assert_exc_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_exc_o |-> $past(acc_valid_i));
  assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_wr |=> (stat & $past(stat)) == $past(stat));
  assert_local_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    task_switch_i |=> (ctrl & LM) == '0);
  assert_global_keep_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    task_switch_i && !ctrl_wr |=> $stable(ctrl & GM));
  assert_step_flag_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    single_step_i |=> stat[STAT_SS_BIT]);
  assert_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> !dbg_exc_o);
endmodule

bind brk_match_unit brk_match_unit_chk #(.NBP(NBP), .AW(AW), .DW(DW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .acc_valid_i   (acc_valid_i),
  .reg_en_i      (reg_en_i),
  .reg_we_i      (reg_we_i),
  .reg_sel_i     (reg_sel_i),
  .cpl_i         (cpl_i),
  .reg_rdata_o   (reg_rdata_o),
  .prot_fault_o  (prot_fault_o),
  .task_switch_i (task_switch_i),
  .single_step_i (single_step_i),
  .dbg_exc_o     (dbg_exc_o),
  .bp_addr       (bp_addr_w),
  .ctrl          (ctrl_w),
  .stat          (stat_w)
);

// File: tb/brk_match_unit_bench.sv
`timescale 1ns/1ps
module brk_match_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        acc_valid_i = 1'b0;
  logic [31:0] acc_addr_i = '0;
  logic [1:0]  acc_kind_i = '0;
  logic        reg_en_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_sel_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [1:0]  cpl_i = '0;
  logic [31:0] reg_rdata_o;
  logic        prot_fault_o;
  logic        task_switch_i = 1'b0;
  logic        new_task_trap_i = 1'b0;
  logic        single_step_i = 1'b0;
  logic        dbg_exc_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  brk_match_unit u_brk_match_unit (.*);

  typedef struct packed {
    logic [3:0]  req;
    logic [1:0]  ty;
    logic [1:0]  ln;
    logic [31:0] bpa;
    logic [31:0] aa;
    logic [1:0]  kind;
    logic        hit;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{4'd4, 2'b00, 2'b00, 32'h1000, 32'h1000, 2'b00, 1'b1}, // R4 exec on fetch
    '{4'd4, 2'b00, 2'b00, 32'h1000, 32'h1000, 2'b01, 1'b0}, // R4 exec on read
    '{4'd4, 2'b01, 2'b00, 32'h2000, 32'h2000, 2'b10, 1'b1}, // R4 write on write
    '{4'd4, 2'b01, 2'b00, 32'h2000, 32'h2000, 2'b01, 1'b0}, // R4 write on read
    '{4'd4, 2'b11, 2'b00, 32'h3000, 32'h3000, 2'b01, 1'b1}, // R4 rw on read
    '{4'd4, 2'b11, 2'b00, 32'h3000, 32'h3000, 2'b10, 1'b1}, // R4 rw on write
    '{4'd4, 2'b11, 2'b00, 32'h3000, 32'h3000, 2'b00, 1'b0}, // R4 rw on fetch
    '{4'd5, 2'b11, 2'b01, 32'h4001, 32'h4000, 2'b01, 1'b1}, // R5 halfword
    '{4'd5, 2'b11, 2'b01, 32'h4000, 32'h4002, 2'b01, 1'b0}, // R5 halfword miss
    '{4'd5, 2'b11, 2'b11, 32'h5000, 32'h5003, 2'b10, 1'b1}, // R5 word
    '{4'd5, 2'b11, 2'b11, 32'h5000, 32'h5004, 2'b10, 1'b0}, // R5 word miss
    '{4'd6, 2'b10, 2'b00, 32'h6000, 32'h6000, 2'b10, 1'b0}, // R6 type 10
    '{4'd6, 2'b11, 2'b10, 32'h6000, 32'h6000, 2'b01, 1'b0}, // R6 length 10
    '{4'd6, 2'b00, 2'b11, 32'h7000, 32'h7000, 2'b00, 1'b0}, // R6 exec wide
    '{4'd5, 2'b11, 2'b00, 32'h8000, 32'h8001, 2'b01, 1'b0}  // R5 byte miss
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] sel, logic [31:0] d);
    @(negedge clk_i);
    reg_en_i = 1; reg_we_i = 1; reg_sel_i = sel; reg_wdata_i = d; cpl_i = 0;
    @(negedge clk_i);
    reg_en_i = 0; reg_we_i = 0;
  endtask

  task automatic rd(logic [2:0] sel, output logic [31:0] d);
    @(negedge clk_i);
    reg_en_i = 1; reg_we_i = 0; reg_sel_i = sel; cpl_i = 0;
    #1 d = reg_rdata_o;
    reg_en_i = 0;
  endtask

  task automatic access(logic [31:0] a, logic [1:0] k);
    @(negedge clk_i);
    acc_valid_i = 1; acc_addr_i = a; acc_kind_i = k;
    @(negedge clk_i);
    acc_valid_i = 0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1
    check("R1 exc", 32'(dbg_exc_o), 0);
    check("R1 fault", 32'(prot_fault_o), 0);
    rd(7, d); check("R1 ctrl", d, 0);
    rd(6, d); check("R1 stat", d, 0);
    rd(0, d); check("R1 bp0", d, 0);

    // R2
    wr(2, 32'hCAFE0002); rd(2, d); check("R2 bp2 readback", d, 32'hCAFE0002);
    wr(4, 32'hFFFFFFFF); rd(4, d); check("R2 reserved", d, 0);

    // R3
    @(negedge clk_i);
    reg_en_i = 1; reg_we_i = 1; reg_sel_i = 3; reg_wdata_i = 32'h1234; cpl_i = 3;
    #1 check("R3 fault on write", 32'(prot_fault_o), 1);
    @(negedge clk_i);
    reg_we_i = 0; reg_sel_i = 2; cpl_i = 1;
    #1 check("R3 fault on read", 32'(prot_fault_o), 1);
    check("R3 read data", reg_rdata_o, 0);
    reg_en_i = 0; cpl_i = 0;
    rd(3, d); check("R3 bp3 unchanged", d, 0);

    // table walk: R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      wr(0, VECS[i].bpa);
      wr(7, (32'(VECS[i].ln) << 18) | (32'(VECS[i].ty) << 16) | 32'h1);
      wr(6, 0);
      access(VECS[i].aa, VECS[i].kind);
      check($sformatf("R%0d vec%0d exc", VECS[i].req, i), 32'(dbg_exc_o), 32'(VECS[i].hit));
      rd(6, d);
      check($sformatf("R%0d vec%0d flag", VECS[i].req, i), d, 32'(VECS[i].hit));
    end

    // R7: disabled breakpoint still flags
    wr(1, 32'h9000);
    wr(7, 32'h3 << 20);
    wr(6, 0);
    access(32'h9000, 2'b01);
    check("R7 no exc when disabled", 32'(dbg_exc_o), 0);
    rd(6, d); check("R7 flag when disabled", d, 32'h2);

    // R8: global enable, one-cycle pulse
    wr(7, (32'h3 << 20) | 32'h8);
    access(32'h9000, 2'b01);
    check("R8 exc high", 32'(dbg_exc_o), 1);
    @(negedge clk_i);
    check("R8 exc pulse ends", 32'(dbg_exc_o), 0);

    // R9: sticky
    access(32'h0001, 2'b01);
    rd(6, d); check("R9 flag kept", d, 32'h2);
    @(negedge clk_i);
    acc_valid_i = 1; acc_addr_i = 32'h9000; acc_kind_i = 2'b01;
    reg_en_i = 1; reg_we_i = 1; reg_sel_i = 6; reg_wdata_i = 0; cpl_i = 0;
    @(negedge clk_i);
    acc_valid_i = 0; reg_en_i = 0; reg_we_i = 0;
    rd(6, d); check("R9 set beats clear", d, 32'h2);
    wr(6, 0); rd(6, d); check("R9 software clear", d, 0);

    // R10
    wr(7, 32'h00F3_03FF);
    @(negedge clk_i); task_switch_i = 1;
    @(negedge clk_i); task_switch_i = 0;
    rd(7, d); check("R10 locals cleared", d, 32'h00F3_02AA);
    @(negedge clk_i);
    reg_en_i = 1; reg_we_i = 1; reg_sel_i = 7; reg_wdata_i = 32'h0000_0155; task_switch_i = 1;
    @(negedge clk_i);
    reg_en_i = 0; reg_we_i = 0; task_switch_i = 0;
    rd(7, d); check("R10 clear beats write", d, 0);

    // R11
    wr(6, 0);
    @(negedge clk_i); task_switch_i = 1; new_task_trap_i = 0;
    @(negedge clk_i); task_switch_i = 0;
    rd(6, d); check("R11 no trap flag", d, 0);
    @(negedge clk_i); single_step_i = 1;
    @(negedge clk_i); single_step_i = 0;
    rd(6, d); check("R11 single step", d, 32'h4000);
    @(negedge clk_i); task_switch_i = 1; new_task_trap_i = 1;
    @(negedge clk_i); task_switch_i = 0; new_task_trap_i = 0;
    rd(6, d); check("R11 task trap", d, 32'hC000);

    // R12
    wr(0, 32'h1000);
    wr(7, 32'h2);
    wr(6, 0);
    @(negedge clk_i);
    acc_valid_i = 0; acc_addr_i = 32'h1000; acc_kind_i = 2'b00;
    @(negedge clk_i);
    check("R12 no exc", 32'(dbg_exc_o), 0);
    rd(6, d); check("R12 no flag", d, 0);
    access(32'h1000, 2'b00);
    check("R8 global on bp0", 32'(dbg_exc_o), 1);

    summary();
  end
endmodule